// File: doc/BRIEF.md
# Reorder Buffer with Incremental Squash

This block keeps in-flight instructions of an out-of-order core in program order and hands them back one at a time, oldest first. Each entry holds a sequence number, a PC, a next PC, a ready-to-commit flag and a squashed flag. An entry is written at the tail through a valid/ready insert stream. It leaves through a valid/ready retire stream, and only when it is at the head and its ready flag is set. A separate completion pin sets the ready flag of one slot. The insert port reports the slot the next accepted entry will occupy, so execution logic can address that slot later.

A squash request names a sequence number. The buffer then walks from its youngest entry toward its oldest, visiting at most `SQW` entries per clock. Every visited entry gets both the squashed flag and the ready flag, so it drains through the normal retire stream with `ret_squashed` high and downstream logic can drop its architectural effects. The walk stops in front of the entry whose sequence number equals the request. If no entry matches, it stops after marking the oldest entry. New inserts and retirements wait until the walk has finished.

Back-pressure rules: an insert is taken on a clock edge where `ins_valid` and `ins_ready` are both high. A retirement happens on a clock edge where `ret_valid` and `ret_ready` are both high. While a stream is not taken, its payload may change freely. `ret_valid` may drop without a handshake when a squash request arrives.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `occupancy`=0, `free_cnt`=DEPTH, `head_ready`=0, `tail_valid`=0, `ret_valid`=0, `sq_done`=1 and `ins_ready`=1.
- R2: `ins_ready` is 1 exactly when occupancy is below DEPTH, no walk is running and `sq_valid` is low. Each accepted insert adds one to `occupancy`, and `free_cnt` always equals DEPTH minus `occupancy`. An `ins_valid` pulse while the buffer is full changes nothing.
- R3: The first insert into an empty buffer makes that entry both head and tail. Each later insert moves the tail readouts (`tail_seq`, `tail_pc`) to the newest entry, and `tail_valid` is 1 whenever the buffer is not empty.
- R4: `ins_slot` gives the slot index the next accepted insert will occupy (head index plus occupancy, modulo DEPTH). A `cpl_valid` pulse with slot index `cpl_slot` sets that entry's ready flag. An entry inserted with `ins_done`=1 is ready at once.
- R5: `head_ready` is 0 when the buffer is empty and otherwise equals the head entry's ready flag. `ret_valid` is `head_ready` gated by an idle walk and a low `sq_valid`. A retirement outputs the head's `ret_seq`, `ret_pc`, `ret_npc` and `ret_squashed`, and moves the head forward by one.
- R6: Entries retire in insertion order across the ring wrap point. After the last entry retires, `tail_valid` returns to 0.
- R7: A squash request is taken in any cycle where `sq_valid` is 1. It latches the target, begins at the current tail and performs its first step in that same cycle. A request on an empty buffer marks nothing and leaves `sq_done` at 1.
- R8: Each cycle the walk visits at most SQW entries, from younger to older. Every visited entry has a sequence number greater than the target and ends with both squashed and ready set. Visiting s+1 entries (step indices 0..s) keeps `sq_done` at 0 for exactly floor(s/SQW) cycles after the request.
- R9: The walk stops when it meets the entry whose sequence number equals the target. It leaves that entry and all older entries with their ready and squashed flags unchanged.
- R10: If no entry matches the target, the walk marks the head entry and stops there, so every entry in the buffer comes out with `ret_squashed`=1.
- R11: While `sq_valid` is high or a walk is running, no insert and no retirement takes place, even with `ins_valid` and `ret_ready` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert can be taken |
| ins_seq | input | SEQ_W | Sequence number of the new entry |
| ins_pc | input | PC_W | PC of the new entry |
| ins_npc | input | PC_W | Next PC of the new entry |
| ins_done | input | 1 | New entry is already complete |
| ins_slot | output | $clog2(DEPTH) | Slot the next insert will occupy |
| cpl_valid | input | 1 | Completion pulse |
| cpl_slot | input | $clog2(DEPTH) | Slot being completed |
| ret_valid | output | 1 | Head entry can retire |
| ret_ready | input | 1 | Consumer takes the head entry |
| ret_seq | output | SEQ_W | Sequence number of the retiring entry |
| ret_pc | output | PC_W | PC of the retiring entry |
| ret_npc | output | PC_W | Next PC of the retiring entry |
| ret_squashed | output | 1 | Retiring entry was squashed |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash target sequence number |
| sq_done | output | 1 | No squash walk in progress |
| occupancy | output | $clog2(DEPTH+1) | Number of live entries |
| free_cnt | output | $clog2(DEPTH+1) | Number of free slots |
| head_ready | output | 1 | Head entry is ready to commit |
| head_pc | output | PC_W | PC of the head entry |
| head_npc | output | PC_W | Next PC of the head entry |
| head_seq | output | SEQ_W | Sequence number of the head entry |
| tail_valid | output | 1 | Buffer holds at least one entry |
| tail_pc | output | PC_W | PC of the tail entry |
| tail_seq | output | SEQ_W | Sequence number of the tail entry |

## Verification
A wrong head pointer or occupancy count shows at once on the head readouts, `free_cnt` and `ins_slot`, and later as an out-of-order or duplicated retirement. A walk that runs too far or not far enough does not show when it happens. It shows as a wrong `ret_squashed` bit, or as a target entry that is ready too early, only when that entry reaches the head during the drain. A wrong step count shows in the cycle `sq_done` rises. The bench therefore sweeps every head offset, fill level and target position, and drains each buffer completely while checking every entry's flags.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Index arithmetic on a ring whose size need not be a power of two.
  function automatic int unsigned ring_fwd(int unsigned base, int unsigned off,
                                           int unsigned depth);
    return (base + (off % depth)) % depth;
  endfunction

  function automatic int unsigned ring_back(int unsigned base, int unsigned off,
                                            int unsigned depth);
    return (base + depth - (off % depth)) % depth;
  endfunction

endpackage

// File: rtl/rob_store.sv
module rob_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned SQW   = 2,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [SEQ_W-1:0]          wr_seq,
  input  logic [PC_W-1:0]           wr_pc,
  input  logic [PC_W-1:0]           wr_npc,
  input  logic                      wr_rdy,
  input  logic                      cpl_en,
  input  logic [IW-1:0]             cpl_idx,
  input  logic [SQW-1:0]            mark_en,
  input  logic [SQW-1:0][IW-1:0]    walk_idx,
  output logic [SQW-1:0][SEQ_W-1:0] walk_seq,
  input  logic [IW-1:0]             head_idx,
  output logic [SEQ_W-1:0]          head_seq,
  output logic [PC_W-1:0]           head_pc,
  output logic [PC_W-1:0]           head_npc,
  output logic                      head_rdy,
  output logic                      head_sqd,
  input  logic [IW-1:0]             tail_idx,
  output logic [SEQ_W-1:0]          tail_seq,
  output logic [PC_W-1:0]           tail_pc
);

  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PC_W-1:0]  pc_q  [DEPTH];
  logic [PC_W-1:0]  npc_q [DEPTH];
  logic [DEPTH-1:0] rdy_q;
  logic [DEPTH-1:0] sqd_q;

  // Payload: written only on insert, no reset needed.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      seq_q[wr_idx] <= wr_seq;
      pc_q[wr_idx]  <= wr_pc;
      npc_q[wr_idx] <= wr_npc;
    end
  end

  // Flags: insert loads, completion and walk marks set.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= '0;
      sqd_q <= '0;
    end else begin
      for (int unsigned e = 0; e < DEPTH; e++) begin
        if (wr_en && (32'(wr_idx) == e)) begin
          rdy_q[e] <= wr_rdy;
          sqd_q[e] <= 1'b0;
        end else begin
          if (cpl_en && (32'(cpl_idx) == e)) rdy_q[e] <= 1'b1;
          for (int unsigned k = 0; k < SQW; k++) begin
            if (mark_en[k] && (32'(walk_idx[k]) == e)) begin
              rdy_q[e] <= 1'b1;
              sqd_q[e] <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int unsigned k = 0; k < SQW; k++) walk_seq[k] = seq_q[walk_idx[k]];
  end

  assign head_seq = seq_q[head_idx];
  assign head_pc  = pc_q[head_idx];
  assign head_npc = npc_q[head_idx];
  assign head_rdy = rdy_q[head_idx];
  assign head_sqd = sqd_q[head_idx];
  assign tail_seq = seq_q[tail_idx];
  assign tail_pc  = pc_q[tail_idx];

endmodule

// File: rtl/rob_walk.sv
module rob_walk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned SQW   = 2,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic [SEQ_W-1:0]          req_seq,
  input  logic                      nonempty,
  input  logic [IW-1:0]             tail_idx,
  input  logic [IW-1:0]             head_idx,
  output logic [SQW-1:0][IW-1:0]    rd_idx,
  input  logic [SQW-1:0][SEQ_W-1:0] rd_seq,
  output logic [SQW-1:0]            mark_en,
  output logic                      busy
);

  logic             busy_q, busy_n, go;
  logic [IW-1:0]    ptr_q, ptr_n, start;
  logic [SEQ_W-1:0] tgt_q, tgt_w;

  // Visit positions for this cycle: start, start-1, ... (younger to older).
  always_comb begin
    start = req ? tail_idx : ptr_q;
    for (int unsigned k = 0; k < SQW; k++)
      rd_idx[k] = IW'(rob_pkg::ring_back(32'(start), k, DEPTH));
    ptr_n = IW'(rob_pkg::ring_back(32'(start), SQW, DEPTH));
  end

  // Walk steps: stop before the target, or after marking the head.
  always_comb begin
    tgt_w   = req ? req_seq : tgt_q;
    go      = req ? nonempty : busy_q;
    mark_en = '0;
    for (int unsigned k = 0; k < SQW; k++) begin
      if (go) begin
        if (rd_seq[k] == tgt_w) begin
          go = 1'b0;
        end else begin
          mark_en[k] = 1'b1;
          if (rd_idx[k] == head_idx) go = 1'b0;
        end
      end
    end
    busy_n = go;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      tgt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      ptr_q  <= ptr_n;
      tgt_q  <= tgt_w;
    end
  end

  assign busy = busy_q;

  for (genvar k = 0; k < SQW; k++) begin : g_chk
    // R8
    mark_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mark_en[k] |-> (rd_seq[k] > tgt_w));
  end

  // R7
  empty_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !nonempty) |=> !busy_q);

endmodule

// File: rtl/rob_top.sv
module rob_top #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SQW   = 2,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned PC_W  = 32,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [PC_W-1:0]  ins_npc,
  input  logic             ins_done,
  output logic [IW-1:0]    ins_slot,
  input  logic             cpl_valid,
  input  logic [IW-1:0]    cpl_slot,
  output logic             ret_valid,
  input  logic             ret_ready,
  output logic [SEQ_W-1:0] ret_seq,
  output logic [PC_W-1:0]  ret_pc,
  output logic [PC_W-1:0]  ret_npc,
  output logic             ret_squashed,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic             sq_done,
  output logic [CW-1:0]    occupancy,
  output logic [CW-1:0]    free_cnt,
  output logic             head_ready,
  output logic [PC_W-1:0]  head_pc,
  output logic [PC_W-1:0]  head_npc,
  output logic [SEQ_W-1:0] head_seq,
  output logic             tail_valid,
  output logic [PC_W-1:0]  tail_pc,
  output logic [SEQ_W-1:0] tail_seq
);

  logic [IW-1:0] head_q, tail_idx;
  logic [CW-1:0] count_q;
  logic          walk_busy, ins_fire, ret_fire, h_rdy, h_sqd;
  logic [SQW-1:0]            mark_en;
  logic [SQW-1:0][IW-1:0]    walk_idx;
  logic [SQW-1:0][SEQ_W-1:0] walk_seq;

  assign tail_idx = (count_q == '0) ? head_q
                  : IW'(rob_pkg::ring_fwd(32'(head_q), 32'(count_q) - 1, DEPTH));
  assign ins_slot = IW'(rob_pkg::ring_fwd(32'(head_q), 32'(count_q), DEPTH));

  assign ins_ready  = (32'(count_q) != DEPTH) && !walk_busy && !sq_valid;
  assign head_ready = (count_q != '0) && h_rdy;
  assign ret_valid  = head_ready && !walk_busy && !sq_valid;
  assign ins_fire   = ins_valid && ins_ready;
  assign ret_fire   = ret_valid && ret_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (ret_fire) head_q <= IW'(rob_pkg::ring_fwd(32'(head_q), 1, DEPTH));
      case ({ins_fire, ret_fire})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  rob_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W), .SQW(SQW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ins_fire), .wr_idx(ins_slot), .wr_seq(ins_seq), .wr_pc(ins_pc),
    .wr_npc(ins_npc), .wr_rdy(ins_done),
    .cpl_en(cpl_valid), .cpl_idx(cpl_slot),
    .mark_en(mark_en), .walk_idx(walk_idx), .walk_seq(walk_seq),
    .head_idx(head_q), .head_seq(head_seq), .head_pc(head_pc),
    .head_npc(head_npc), .head_rdy(h_rdy), .head_sqd(h_sqd),
    .tail_idx(tail_idx), .tail_seq(tail_seq), .tail_pc(tail_pc)
  );

  rob_walk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQW(SQW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req(sq_valid), .req_seq(sq_seq), .nonempty(count_q != '0),
    .tail_idx(tail_idx), .head_idx(head_q),
    .rd_idx(walk_idx), .rd_seq(walk_seq), .mark_en(mark_en), .busy(walk_busy)
  );

  assign ret_seq      = head_seq;
  assign ret_pc       = head_pc;
  assign ret_npc      = head_npc;
  assign ret_squashed = h_sqd;
  assign sq_done      = !walk_busy;
  assign occupancy    = count_q;
  assign free_cnt     = CW'(DEPTH) - count_q;
  assign tail_valid   = (count_q != '0);

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occupancy) <= DEPTH);

  // R2
  ins_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && !(ret_valid && ret_ready))
      |=> occupancy == $past(occupancy) + CW'(1));

  // R5
  ret_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready && !(ins_valid && ins_ready))
      |=> occupancy == $past(occupancy) - CW'(1));

  // R6
  last_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready && !ins_valid && occupancy == CW'(1)) |=> !tail_valid);

  // R11
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sq_done && !sq_valid) |=> $stable(head_seq) && $stable(occupancy));

endmodule

// File: tb/test_rob_top.sv
module test_rob_top;
  localparam int unsigned DEPTH = 6;
  localparam int unsigned SQW   = 2;
  localparam int unsigned SEQ_W = 16;
  localparam int unsigned PC_W  = 32;
  localparam int unsigned IW    = $clog2(DEPTH);
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam time CLK_PERIOD    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_done = 0, cpl_valid = 0, ret_ready = 0, sq_valid = 0;
  logic [SEQ_W-1:0] ins_seq = '0, sq_seq = '0;
  logic [PC_W-1:0]  ins_pc = '0, ins_npc = '0;
  logic [IW-1:0]    cpl_slot = '0;
  logic ins_ready, ret_valid, ret_squashed, sq_done, head_ready, tail_valid;
  logic [IW-1:0] ins_slot;
  logic [SEQ_W-1:0] ret_seq, head_seq, tail_seq;
  logic [PC_W-1:0] ret_pc, ret_npc, head_pc, head_npc, tail_pc;
  logic [CW-1:0] occupancy, free_cnt;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rob_top #(.DEPTH(DEPTH), .SQW(SQW), .SEQ_W(SEQ_W), .PC_W(PC_W)) i_rob_top (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_seq(ins_seq),
    .ins_pc(ins_pc), .ins_npc(ins_npc), .ins_done(ins_done), .ins_slot(ins_slot),
    .cpl_valid(cpl_valid), .cpl_slot(cpl_slot),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_seq(ret_seq),
    .ret_pc(ret_pc), .ret_npc(ret_npc), .ret_squashed(ret_squashed),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_done(sq_done),
    .occupancy(occupancy), .free_cnt(free_cnt), .head_ready(head_ready),
    .head_pc(head_pc), .head_npc(head_npc), .head_seq(head_seq),
    .tail_valid(tail_valid), .tail_pc(tail_pc), .tail_seq(tail_seq)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    ins_valid = 0; cpl_valid = 0; ret_ready = 0; sq_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk("R1", "occupancy", occupancy, 0);
    chk("R1", "free_cnt", free_cnt, DEPTH);
    chk("R1", "head_ready", head_ready, 0);
    chk("R1", "tail_valid", tail_valid, 0);
    chk("R1", "ret_valid", ret_valid, 0);
    chk("R1", "sq_done", sq_done, 1);
    chk("R1", "ins_ready", ins_ready, 1);
  endtask

  // Insert one entry; called just after a negedge, returns just after the next.
  task automatic put(input int s, input bit d, input int exp_slot);
    ins_valid = 1; ins_seq = SEQ_W'(s); ins_pc = PC_W'(1000 + 4 * s);
    ins_npc = PC_W'(1004 + 4 * s); ins_done = d;
    #1;
    // R4
    chk("R4", "ins_slot", ins_slot, exp_slot);
    chk("R2", "ins_ready", ins_ready, 1);
    @(negedge clk);
    ins_valid = 0;
    #1;
    // R3
    chk("R3", "tail_seq", tail_seq, s);
    chk("R3", "tail_pc", tail_pc, 1000 + 4 * s);
    chk("R3", "tail_valid", tail_valid, 1);
  endtask

  // Retire the head, which must be ready.
  task automatic take(input int s, input bit sq);
    ret_ready = 1;
    #1;
    // R5
    chk("R5", "ret_valid", ret_valid, 1);
    chk("R5", "ret_seq", ret_seq, s);
    chk("R5", "ret_pc", ret_pc, 1000 + 4 * s);
    chk("R5", "ret_npc", ret_npc, 1004 + 4 * s);
    // R8 / R10
    chk("R8", "ret_squashed", ret_squashed, sq);
    @(negedge clk);
    ret_ready = 0;
    #1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R7: squash on an empty buffer changes nothing.
    sq_valid = 1; sq_seq = 16'd7;
    @(negedge clk);
    sq_valid = 0;
    #1;
    chk("R7", "sq_done after empty squash", sq_done, 1);
    chk("R7", "occupancy after empty squash", occupancy, 0);
    chk("R7", "ins_ready after empty squash", ins_ready, 1);

    for (int off = 0; off < int'(DEPTH); off++) begin
      for (int n = 1; n <= int'(DEPTH); n++) begin
        for (int t = 0; t <= n; t++) begin
          int base, s_last, exp_low, low;
          bit done_b [DEPTH];
          bit mark_b [DEPTH];
          do_reset();
          // Move the head to slot off through pre-retired entries.
          for (int j = 0; j < off; j++) put(50 + j, 1'b1, j);
          for (int j = 0; j < off; j++) take(50 + j, 1'b0);
          base = 100;
          for (int i = 0; i < n; i++) begin
            done_b[i] = ((i + t) % 3) == 0;
            mark_b[i] = (t < n) ? (i > t) : 1'b1;
            put(base + i, done_b[i], (off + i) % int'(DEPTH));
            // R2
            chk("R2", "occupancy", occupancy, i + 1);
            chk("R2", "free_cnt", free_cnt, int'(DEPTH) - i - 1);
            // R3
            chk("R3", "head_seq", head_seq, base);
          end
          if (n == int'(DEPTH)) begin
            // R2: insert while full has no effect
            ins_valid = 1; ins_seq = 16'd999;
            #1;
            chk("R2", "ins_ready when full", ins_ready, 0);
            @(negedge clk);
            ins_valid = 0;
            #1;
            chk("R2", "occupancy after full insert", occupancy, DEPTH);
            chk("R2", "tail_seq after full insert", tail_seq, base + n - 1);
          end
          // Squash: hold insert and retire requests high in the same cycle.
          sq_valid = 1; sq_seq = SEQ_W'((t < n) ? base + t : base - 1);
          ins_valid = 1; ins_seq = 16'd777; ret_ready = 1;
          #1;
          // R11
          chk("R11", "ins_ready with squash", ins_ready, 0);
          chk("R11", "ret_valid with squash", ret_valid, 0);
          @(negedge clk);
          sq_valid = 0;
          #1;
          s_last = (t < n) ? (n - 1 - t) : (n - 1);
          exp_low = s_last / int'(SQW);
          low = 0;
          while (!sq_done && low < 20) begin
            // R11
            chk("R11", "ins_ready during walk", ins_ready, 0);
            chk("R11", "ret_valid during walk", ret_valid, 0);
            low++;
            @(negedge clk);
            #1;
          end
          ins_valid = 0; ret_ready = 0;
          // R8
          chk("R8", "walk busy cycles", low, exp_low);
          chk("R11", "occupancy after walk", occupancy, n);
          // Drain in order, completing entries that are not ready.
          for (int i = 0; i < n; i++) begin
            bit exp_rdy;
            exp_rdy = done_b[i] || mark_b[i];
            // R9 / R10
            chk((t < n && i <= t) ? "R9" : "R10", "head_ready", head_ready, exp_rdy);
            chk("R6", "head_seq order", head_seq, base + i);
            chk("R5", "head_npc", head_npc, 1004 + 4 * (base + i));
            if (!exp_rdy) begin
              cpl_valid = 1; cpl_slot = IW'((off + i) % int'(DEPTH));
              @(negedge clk);
              cpl_valid = 0;
              #1;
              // R4
              chk("R4", "head_ready after completion", head_ready, 1);
            end
            take(base + i, mark_b[i]);
          end
          // R6
          chk("R6", "tail_valid after drain", tail_valid, 0);
          chk("R5", "head_ready when empty", head_ready, 0);
          chk("R2", "free_cnt after drain", free_cnt, DEPTH);
        end
      end
    end

    report();
    $finish;
  end

endmodule